// File: doc/BRIEF.md
# Audio Codec Power-Control Register with ADC Start-Up Timer

This block holds the 8-bit power-control word of an audio codec. Software reaches it through a plain register port: an address, a write strobe, write data and read data. Four register bits drive the enables for the mid-rail reference generator, the programmable filter, and the left and right microphone/ADC paths. The block enforces an interlock: the reference must be on whenever any other path is on. A write that breaks this rule is repaired in hardware, and a sticky flag records the event.

Each ADC channel has its own start-up timer. When a channel's enable goes from 0 to 1, the timer counts sample-rate strobes. The channel's data-valid output stays low until `INIT_TICKS` strobes (1059 by default) have been counted. Clearing the enable ends the count at once.

An asynchronous, active-low hard power-down pin is synchronised to the clock. While it is low, it returns the register to 0x00, clears the timers and the flag, and blocks writes. No stream passes through the block, so every pin is a plain level or strobe and none uses a valid/ready handshake.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: At address `REG_ADDR`, the register bits map to outputs as follows: bit 0 → `pwr_vref`, bit 1 → `pwr_filt`, bit 4 → `pwr_adc_l`, bit 5 → `pwr_adc_r`. A write takes effect on the clock edge that samples `wr_en`, and the outputs show the stored bits from that edge onward.
- R2: Bits 7, 6, 3 and 2 are not writable and always read 0, so writing 0xFF stores 0x33. `rdata` is combinational from `addr`. Reads at any other address return 0, and writes at any other address change nothing.
- R3: After `rst_n` is released, the register reads 0x00, and every enable, every data-valid output and `cfg_err` are low.
- R4: If a write would store bit 1, 4 or 5 as 1 with bit 0 as 0, the block stores bit 0 as 1 and sets `cfg_err`. For example, writing 0x30 stores 0x31.
- R5: `cfg_err` stays high through later legal writes. Only reset or a hard power-down clears it.
- R6: On the edge where a channel enable goes from 0 to 1, that channel's valid output is low. It rises on the edge that samples the `INIT_TICKS`-th `fs_tick` after that edge; a strobe sampled on the write edge itself is not counted. The left and right channels time independently.
- R7: Only cycles with `fs_tick` high advance the timer. Any number of cycles without a strobe leaves valid low.
- R8: Clearing a channel enable drops its valid output on the same edge, and aborts any count in progress. Setting the enable again restarts the count from zero.
- R9: Writing 1 to a channel bit that is already 1 does not restart its timer and does not drop its valid output.
- R10: `pdn_n` passes through two synchronising flops. From the third rising edge after `pdn_n` goes low, the register holds 0x00, all outputs and `cfg_err` are low, and writes are ignored for as long as the synchronised level stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Asynchronous active-low hard power-down |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| pwr_vref | output | 1 | Reference generator enable |
| pwr_filt | output | 1 | Programmable filter enable |
| pwr_adc_l | output | 1 | Left microphone/ADC enable |
| pwr_adc_r | output | 1 | Right microphone/ADC enable |
| adc_valid_l | output | 1 | Left ADC data valid |
| adc_valid_r | output | 1 | Right ADC data valid |
| cfg_err | output | 1 | Sticky interlock-violation flag |

## Verification
The bench builds the block with `INIT_TICKS` = 12, `ADDR_W` = 4 and `REG_ADDR` = 0. A 12-strobe window makes it cheap to stop one strobe short of completion and then land exactly on it. It also allows an abort part-way through a count, followed by a restart whose total would have finished early had the abort not cleared the count. Address 3 stands in for every non-matching address. The default 1059-strobe window uses the same counter compare at a wider `CNT_W`.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned BIT_VREF  = 0;
  localparam int unsigned BIT_FILT  = 1;
  localparam int unsigned BIT_ADC_L = 4;
  localparam int unsigned BIT_ADC_R = 5;
  localparam int unsigned N_CH      = 2;
  // Bits that can hold a 1; the rest read as zero.
  localparam logic [REG_W-1:0] WR_MASK = 8'h33;
  // Enables that depend on the reference being on.
  localparam logic [REG_W-1:0] DEP_MASK = 8'h32;

  function automatic int unsigned ch_bit(int unsigned ch);
    return (ch == 0) ? BIT_ADC_L : BIT_ADC_R;
  endfunction
endpackage

// File: rtl/cpc_pdn_sync.sv
module cpc_pdn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_n,
  output logic pdn_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], pdn_n};
  end

  assign pdn_s = chain[STAGES-1];
endmodule

// File: rtl/cpc_ctrl_reg.sv
module cpc_ctrl_reg
  import codec_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_s,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  reg_q,
  output logic [N_CH-1:0]   adc_en_nxt,
  output logic              err_q
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic [REG_W-1:0] reg_nxt;
  logic [REG_W-1:0] cand;
  logic             fix;
  logic             err_nxt;

  always_comb begin
    reg_nxt = reg_q;
    cand    = wdata & WR_MASK;
    fix     = 1'b0;
    if (!pdn_s) begin
      reg_nxt = '0;
    end else if (wr_en && addr == HIT_ADDR) begin
      if (|(cand & DEP_MASK) && !cand[BIT_VREF]) begin
        cand[BIT_VREF] = 1'b1;
        fix            = 1'b1;
      end
      reg_nxt = cand;
    end
    err_nxt = pdn_s && (err_q || fix);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_nxt
    assign adc_en_nxt[c] = reg_nxt[ch_bit(c)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
      err_q <= 1'b0;
    end else begin
      reg_q <= reg_nxt;
      err_q <= err_nxt;
    end
  end
endmodule

// File: rtl/cpc_init_timer.sv
module cpc_init_timer #(
  parameter int unsigned INIT_TICKS = 1059,
  localparam int unsigned CNT_W = $clog2(INIT_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_cur,
  input  logic en_nxt,
  input  logic tick,
  output logic valid
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_TICKS - 1);

  logic             run;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      valid <= 1'b0;
    end else if (!en_nxt) begin
      run   <= 1'b0;
      cnt   <= '0;
      valid <= 1'b0;
    end else if (!en_cur) begin
      run   <= 1'b1;
      cnt   <= '0;
      valid <= 1'b0;
    end else if (run && tick) begin
      if (cnt == LAST) begin
        run   <= 1'b0;
        cnt   <= '0;
        valid <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_ADDR   = 0,
  parameter int unsigned INIT_TICKS = 1059
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_n,
  input  logic              fs_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              pwr_vref,
  output logic              pwr_filt,
  output logic              pwr_adc_l,
  output logic              pwr_adc_r,
  output logic              adc_valid_l,
  output logic              adc_valid_r,
  output logic              cfg_err
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic             pdn_s;
  logic [REG_W-1:0] reg_q;
  logic [N_CH-1:0]  adc_en_nxt;
  logic [N_CH-1:0]  valid;

  cpc_pdn_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pdn_n (pdn_n),
    .pdn_s (pdn_s)
  );

  cpc_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdn_s      (pdn_s),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .reg_q      (reg_q),
    .adc_en_nxt (adc_en_nxt),
    .err_q      (cfg_err)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cpc_init_timer #(.INIT_TICKS(INIT_TICKS)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_cur (reg_q[ch_bit(c)]),
      .en_nxt (adc_en_nxt[c]),
      .tick   (fs_tick),
      .valid  (valid[c])
    );
  end

  assign rdata       = (addr == HIT_ADDR) ? reg_q : '0;
  assign pwr_vref    = reg_q[BIT_VREF];
  assign pwr_filt    = reg_q[BIT_FILT];
  assign pwr_adc_l   = reg_q[BIT_ADC_L];
  assign pwr_adc_r   = reg_q[BIT_ADC_R];
  assign adc_valid_l = valid[0];
  assign adc_valid_r = valid[1];
endmodule

// File: rtl/codec_pwr_ctrl_chk.sv
module codec_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pdn_s,
  input logic       fs_tick,
  input logic [7:0] rdata,
  input logic       pwr_vref,
  input logic       pwr_filt,
  input logic       pwr_adc_l,
  input logic       pwr_adc_r,
  input logic       adc_valid_l,
  input logic       adc_valid_r,
  input logic       cfg_err
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:6] == 2'b00 && rdata[3:2] == 2'b00);

  p_vref_interlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_filt || pwr_adc_l || pwr_adc_r) |-> pwr_vref);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_err) |-> !$past(pdn_s));

  p_valid_needs_en_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid_l |-> pwr_adc_l);

  p_valid_needs_en_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid_r |-> pwr_adc_r);

  p_valid_on_tick_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_valid_l) |-> $past(fs_tick));

  p_valid_on_tick_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_valid_r) |-> $past(fs_tick));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_adc_r) |-> !adc_valid_r);

  p_pdn_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_s |=> (!pwr_vref && !pwr_filt && !pwr_adc_l && !pwr_adc_r &&
                !adc_valid_l && !adc_valid_r && !cfg_err));
endmodule

bind codec_pwr_ctrl codec_pwr_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pdn_s       (pdn_s),
  .fs_tick     (fs_tick),
  .rdata       (rdata),
  .pwr_vref    (pwr_vref),
  .pwr_filt    (pwr_filt),
  .pwr_adc_l   (pwr_adc_l),
  .pwr_adc_r   (pwr_adc_r),
  .adc_valid_l (adc_valid_l),
  .adc_valid_r (adc_valid_r),
  .cfg_err     (cfg_err)
);

// File: tb/codec_pwr_ctrl_tb_top.sv
module codec_pwr_ctrl_tb_top;
  localparam int INIT = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn_n = 1'b1;
  logic       fs_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic pwr_vref, pwr_filt, pwr_adc_l, pwr_adc_r;
  logic adc_valid_l, adc_valid_r, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  codec_pwr_ctrl #(.ADDR_W(4), .REG_ADDR(0), .INIT_TICKS(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fs_tick(fs_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwr_vref(pwr_vref), .pwr_filt(pwr_filt),
    .pwr_adc_l(pwr_adc_l), .pwr_adc_r(pwr_adc_r),
    .adc_valid_l(adc_valid_l), .adc_valid_r(adc_valid_r), .cfg_err(cfg_err)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: register contents, sync stages, per-channel timers.
  int m_reg, m_err, m_s1, m_s2, m_nxt, m_fix;
  int m_run[2], m_cnt[2], m_val[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_err = 0; m_s1 = 0; m_s2 = 0;
      for (int c = 0; c < 2; c++) begin m_run[c] = 0; m_cnt[c] = 0; m_val[c] = 0; end
    end else begin
      m_nxt = m_reg;
      m_fix = 0;
      if (m_s2 == 0) m_nxt = 0;
      else if (wr_en && addr == 0) begin
        m_nxt = wdata & 'h33;
        if ((m_nxt & 'h32) != 0 && (m_nxt & 1) == 0) begin
          m_nxt = m_nxt | 1;
          m_fix = 1;
        end
      end
      m_err = (m_s2 == 0) ? 0 : (m_err | m_fix);
      for (int c = 0; c < 2; c++) begin
        int b;
        b = (c == 0) ? 4 : 5;
        if (((m_nxt >> b) & 1) == 0) begin
          m_run[c] = 0; m_cnt[c] = 0; m_val[c] = 0;
        end else if (((m_reg >> b) & 1) == 0) begin
          m_run[c] = 1; m_cnt[c] = 0; m_val[c] = 0;
        end else if (m_run[c] == 1 && fs_tick) begin
          m_cnt[c]++;
          if (m_cnt[c] == INIT) begin m_run[c] = 0; m_cnt[c] = 0; m_val[c] = 1; end
        end
      end
      m_reg = m_nxt;
      m_s2 = m_s1;
      m_s1 = int'(pdn_n);
    end
  end

  // Compare against the reference every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (!done) begin
      chk("R1", "pwr_vref",  int'(pwr_vref),  m_reg & 1);
      chk("R1", "pwr_filt",  int'(pwr_filt),  (m_reg >> 1) & 1);
      chk("R1", "pwr_adc_l", int'(pwr_adc_l), (m_reg >> 4) & 1);
      chk("R1", "pwr_adc_r", int'(pwr_adc_r), (m_reg >> 5) & 1);
      chk("R2", "rdata",     int'(rdata),     (addr == 0) ? m_reg : 0);
      chk("R4", "cfg_err",   int'(cfg_err),   m_err);
      chk("R6", "valid_l",   int'(adc_valid_l), m_val[0]);
      chk("R6", "valid_r",   int'(adc_valid_r), m_val[1]);
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    @(negedge clk); #1;
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 fs_tick = 1'b1;
      @(negedge clk); #1 fs_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    idle(3);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(4);
    // R3: reset state
    rd(0, v); chk("R3", "reset rdata", v, 'h00);
    chk("R3", "reset enables", int'({pwr_vref, pwr_filt, pwr_adc_l, pwr_adc_r}), 0);
    chk("R3", "reset err/valid", int'({cfg_err, adc_valid_l, adc_valid_r}), 0);

    // R1: reference alone
    wr(0, 'h01); rd(0, v); chk("R1", "vref only", v, 'h01);
    chk("R1", "pwr_vref pin", int'(pwr_vref), 1);

    // R2: reserved bits dropped; both channels start
    wr(0, 'hFF); rd(0, v); chk("R2", "masked write", v, 'h33);
    chk("R4", "no err on legal write", int'(cfg_err), 0);

    // R7: no strobes, no progress
    idle(50);
    chk("R7", "valid_l without ticks", int'(adc_valid_l), 0);

    // R6: exact window
    ticks(INIT - 1);
    chk("R6", "valid_l one short", int'(adc_valid_l), 0);
    ticks(1);
    chk("R6", "valid_l at window", int'(adc_valid_l), 1);
    chk("R6", "valid_r at window", int'(adc_valid_r), 1);

    // R9: rewrite of set bits keeps valid
    wr(0, 'h33); idle(1);
    chk("R9", "valid_l after rewrite", int'(adc_valid_l), 1);

    // R8: clear, restart, abort, restart from zero
    wr(0, 'h13);
    chk("R8", "valid_r after clear", int'(adc_valid_r), 0);
    wr(0, 'h33); ticks(5);
    wr(0, 'h13);
    chk("R8", "valid_r after abort", int'(adc_valid_r), 0);
    wr(0, 'h33); ticks(INIT - 1);
    chk("R8", "valid_r restarted from zero", int'(adc_valid_r), 0);
    chk("R6", "left independent", int'(adc_valid_l), 1);
    ticks(1);
    chk("R8", "valid_r after full restart", int'(adc_valid_r), 1);

    // R4: clearing reference while others set
    wr(0, 'h30); rd(0, v); chk("R4", "forced vref", v, 'h31);
    chk("R4", "err raised", int'(cfg_err), 1);
    wr(0, 'h00); rd(0, v); chk("R5", "all off", v, 'h00);
    chk("R5", "err sticky", int'(cfg_err), 1);
    wr(0, 'h02); rd(0, v); chk("R4", "filter forces vref", v, 'h03);

    // R2: other address
    wr(3, 'h01); rd(0, v); chk("R2", "foreign write ignored", v, 'h03);
    rd(3, v); chk("R2", "foreign read zero", v, 0);

    // R10: hard power-down
    wr(0, 'h33); ticks(INIT);
    @(negedge clk); #1 pdn_n = 1'b0;
    idle(4);
    rd(0, v); chk("R10", "pdn register", v, 0);
    chk("R10", "pdn err", int'(cfg_err), 0);
    chk("R10", "pdn valid", int'({adc_valid_l, adc_valid_r}), 0);
    wr(0, 'h01); rd(0, v); chk("R10", "write blocked", v, 0);
    @(negedge clk); #1 pdn_n = 1'b1;
    idle(4);
    wr(0, 'h01); rd(0, v); chk("R10", "write after release", v, 'h01);
    idle(3);
    finish_run();
  end
endmodule